// File: doc/BRIEF.md
# Chip-Enable-Framed Byte Memory Cycle Sequencer

This block sits on the host side of a byte-wide nonvolatile RAM that has a 15-bit address and 8-bit data. The memory latches its address when chip enable falls, and it needs chip enable to go high again after every access. The block takes one read or write request at a time and turns it into a single chip-enable-framed cycle. Each cycle has an address setup clock, a chip-enable-low window, and then a precharge interval. When the cycle ends, the block reports the result with a one-clock done pulse.

All memory timing is given as nanosecond parameters. These are rounded up to whole clocks of `CLK_PERIOD_NS`. The chip-enable-low window is the largest of three values: the minimum active time, the access time and the minimum write-enable pulse. The precharge is the larger of two values: the minimum precharge time, and what the full cycle time still requires after the low window. With the defaults (10 ns clock) the low window is 15 clocks and the precharge is 9 clocks.

Top module: `fram_cycle_seq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `memCeN`, `memWeN` and `memOeN` are 1, and `busy`, `done` and `memDoutEn` are 0.
- R2: A request (`reqValid` high at a clock edge) is accepted only while `busy` is 0. A request presented while `busy` is 1 is ignored: it produces no cycle, no `done` pulse and no change to memory contents.
- R3: The address of an accepted request appears on `memAddr` one clock before `memCeN` falls. It stays unchanged for as long as `memCeN` is low.
- R4: Each access holds `memCeN` low for exactly CE_LOW_CYC clocks. CE_LOW_CYC is the maximum of ceil(150/T), ceil(150/T) and ceil(50/T) for active time, access time and write pulse, which is 15 at T = 10 ns.
- R5: After every access `memCeN` returns to 1 and stays there for at least PC_CYC clocks before the next fall. PC_CYC is max(ceil(85/T), ceil(235/T) - CE_LOW_CYC, 1), which is 9 at T = 10 ns.
- R6: In a read (`reqWrite` = 0), `memWeN` stays 1 and `memOeN` is low exactly while `memCeN` is low. `rdData` takes the value of `memDin` at the last clock edge of the low window and holds it until the next read.
- R7: In a write (`reqWrite` = 1), `memWeN` is low exactly while `memCeN` is low and `memOeN` stays 1. `memDoutEn` is 1, with `memDout` equal to the request data, from the clock after acceptance until `memCeN` rises.
- R8: `done` is a one-clock pulse. It is high in the cycle that begins 1 + CE_LOW_CYC + PC_CYC clock edges after the accepting edge. `busy` is 1 from the cycle after acceptance until the precharge ends, and it is 0 while `done` is 1.
- R9: A request presented in the cycle in which `done` is high is accepted at once, so accesses can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Request address |
| reqWdata | input | 8 | Request write data |
| memCeN | output | 1 | Memory chip enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memAddr | output | 15 | Memory address |
| memDout | output | 8 | Data driven toward memory |
| memDoutEn | output | 1 | Enable for the data driver toward memory |
| memDin | input | 8 | Data returned from memory |
| rdData | output | 8 | Last captured read byte |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | An access is in progress |

## Verification
Each accepted request is pushed onto a scoreboard together with its due cycle. The due cycle is the presenting cycle plus 2 + CE_LOW_CYC + PC_CYC, because the accepting edge, the setup edge, the low window and the precharge each add registers on the way to `done`. The monitor samples on falling clock edges and pops an item only when `done` is high. It compares the arrival cycle with the due cycle, and for reads it compares `rdData` with a reference memory. The pin checks for each cycle run at the falling edge that first shows `memCeN` changed. That is one edge after the RTL register moved, so the low and high lengths are counted in whole clocks.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture request fields
    logic ceEnd;  // last clock of the CE-low window
  } dpStrobe_t;

  function automatic int unsigned ceilDiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned maxU(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int unsigned CE_LOW_CYC = 15,
  parameter int unsigned PC_CYC     = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output dpStrobe_t strobe,
  output logic      memCeN,
  output logic      memWeN,
  output logic      memOeN,
  output logic      busy,
  output logic      done
);

  localparam int unsigned CNT_MAX = maxU(CE_LOW_CYC, PC_CYC);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam int unsigned RUN_W   = $clog2(CNT_MAX + 2);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             writeQ;

  assign strobe.load  = (state == ST_IDLE) && reqValid;
  assign strobe.ceEnd = (state == ST_ACTIVE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      writeQ <= 1'b0;
      memCeN <= 1'b1;
      memWeN <= 1'b1;
      memOeN <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state  <= ST_SETUP;
            writeQ <= reqWrite;
            busy   <= 1'b1;
          end
        end
        ST_SETUP: begin
          state  <= ST_ACTIVE;
          cnt    <= CNT_W'(CE_LOW_CYC - 1);
          memCeN <= 1'b0;
          memWeN <= !writeQ;
          memOeN <= writeQ;
        end
        ST_ACTIVE: begin
          if (cnt == '0) begin
            state  <= ST_PRE;
            cnt    <= CNT_W'(PC_CYC - 1);
            memCeN <= 1'b1;
            memWeN <= 1'b1;
            memOeN <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // run-length counters on the CE pin, used only by the checks below
  logic [RUN_W-1:0] lowRun;
  logic [RUN_W-1:0] hiRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun <= '0;
      hiRun  <= RUN_W'(PC_CYC);
    end else begin
      lowRun <= memCeN ? '0 : lowRun + 1'b1;
      if (!memCeN)                   hiRun <= '0;
      else if (hiRun < RUN_W'(PC_CYC)) hiRun <= hiRun + 1'b1;
    end
  end

  AST_CE_LOW_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> (lowRun == RUN_W'(CE_LOW_CYC))); // R4
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> (hiRun >= RUN_W'(PC_CYC))); // R5
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN); // R7
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8

endmodule

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic [DATA_W-1:0] rdData
);

  logic isWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr   <= '0;
      memDout   <= '0;
      memDoutEn <= 1'b0;
      rdData    <= '0;
      isWrite   <= 1'b0;
    end else begin
      if (strobe.load) begin
        memAddr   <= reqAddr;
        memDout   <= reqWdata;
        isWrite   <= reqWrite;
        memDoutEn <= reqWrite;
      end
      if (strobe.ceEnd) begin
        memDoutEn <= 1'b0;
        if (!isWrite) rdData <= memDin;
      end
    end
  end

  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memDoutEn && $past(memDoutEn)) |-> $stable(memDout)); // R7
  AST_NO_LOAD_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.ceEnd)); // R2

endmodule

// File: rtl/fram_cycle_seq.sv
module fram_cycle_seq
  import fcs_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_CE_MIN_NS   = 150,
  parameter int unsigned T_ACC_NS      = 150,
  parameter int unsigned T_WE_PULSE_NS = 50,
  parameter int unsigned T_PC_NS       = 85,
  parameter int unsigned T_CYC_NS      = 235
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              busy
);

  localparam int unsigned CE_LOW_CYC = maxU(maxU(ceilDiv(T_CE_MIN_NS, CLK_PERIOD_NS),
                                                 ceilDiv(T_ACC_NS, CLK_PERIOD_NS)),
                                            ceilDiv(T_WE_PULSE_NS, CLK_PERIOD_NS));
  localparam int unsigned CYC_CLKS   = ceilDiv(T_CYC_NS, CLK_PERIOD_NS);
  localparam int unsigned PC_FILL    = (CYC_CLKS > CE_LOW_CYC) ? CYC_CLKS - CE_LOW_CYC : 0;
  localparam int unsigned PC_CYC     = maxU(maxU(ceilDiv(T_PC_NS, CLK_PERIOD_NS), PC_FILL), 1);

  dpStrobe_t strobe;

  fcs_ctrl #(
    .CE_LOW_CYC(CE_LOW_CYC),
    .PC_CYC    (PC_CYC)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .strobe  (strobe),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .busy    (busy),
    .done    (done)
  );

  fcs_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .memDoutEn(memDoutEn),
    .rdData   (rdData)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> $stable(memAddr)); // R3
  AST_DOUT_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memDoutEn && !memCeN) |-> !memWeN); // R7

endmodule

// File: tb/test_fram_cycle_seq.sv
module test_fram_cycle_seq;

  localparam int CLK_NS = 10;
  localparam int CE_LOW = ((150 + CLK_NS - 1) / CLK_NS);
  localparam int PC_A   = ((85 + CLK_NS - 1) / CLK_NS);
  localparam int PC_B   = ((235 + CLK_NS - 1) / CLK_NS) - CE_LOW;
  localparam int PC     = (PC_A > PC_B) ? PC_A : PC_B;
  localparam int LAT    = 2 + CE_LOW + PC;

  typedef struct {
    bit          wr;
    logic [14:0] a;
    logic [7:0]  d;
    int          due;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        memCeN, memWeN, memOeN, memDoutEn, done, busy;
  logic [14:0] memAddr;
  logic [7:0]  memDout, memDin, rdData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  item_t sbQ[$];
  logic [7:0] refMem [int];
  logic [7:0] modelMem [int];
  logic [7:0] rdVal = 8'h00;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign memDin = (!memCeN && !memOeN) ? rdVal : 8'h00;

  fram_cycle_seq #(.CLK_PERIOD_NS(CLK_NS)) i_fram_cycle_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memAddr(memAddr), .memDout(memDout), .memDoutEn(memDoutEn),
    .memDin(memDin), .rdData(rdData), .done(done), .busy(busy)
  );

  function automatic logic [7:0] initVal(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // driver: waits for an idle cycle, presents the request for one clock, pushes expectation
  task automatic doAccess(input bit wr, input logic [14:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    it.wr = wr; it.a = a; it.due = cyc + LAT;
    if (wr) begin
      it.d = d;
      refMem[int'(a)] = d;
    end else begin
      it.d = refMem.exists(int'(a)) ? refMem[int'(a)] : initVal(a);
    end
    sbQ.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // request presented while busy; must be ignored (R2)
  task automatic pokeWhileBusy(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!busy) @(negedge clk);
    repeat (3) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
  endtask

  // memory model and monitor
  logic        prevCe = 1'b1;
  logic        prevDone = 1'b0;
  logic [14:0] prevAddr = '0;
  logic [14:0] latAddr = '0;
  logic [7:0]  lastDout = '0;
  bit          lastDoutEn = 1'b0;
  bit          wrFlag = 1'b0;
  bit          ctlBad = 1'b0;
  int          lowCnt = 0;
  int          hiCnt = 1000;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevCe && !memCeN) begin
        chk(memAddr == prevAddr, "R3", "address not set up before CE fall", memAddr, prevAddr);
        chk(hiCnt >= PC, "R5", "precharge too short", hiCnt, PC);
        latAddr = memAddr;
        wrFlag  = !memWeN;
        ctlBad  = 1'b0;
        lowCnt  = 0;
        rdVal   = modelMem.exists(int'(memAddr)) ? modelMem[int'(memAddr)] : initVal(memAddr);
      end
      if (!memCeN) begin
        lowCnt++;
        if (memAddr != latAddr) ctlBad = 1'b1;
        if (wrFlag && (memWeN || !memOeN)) ctlBad = 1'b1;
        if (!wrFlag && (!memWeN || memOeN)) ctlBad = 1'b1;
        lastDout   = memDout;
        lastDoutEn = memDoutEn;
      end
      if (!prevCe && memCeN) begin
        hiCnt = 1;
        chk(lowCnt == CE_LOW, "R4", "CE low length", lowCnt, CE_LOW);
        chk(!ctlBad, wrFlag ? "R7" : "R6", "WE/OE/address inside CE window", ctlBad, 0);
        if (sbQ.size() > 0) begin
          chk(latAddr == sbQ[0].a, "R3", "latched address", latAddr, sbQ[0].a);
          chk(wrFlag == sbQ[0].wr, "R6", "cycle kind", wrFlag, sbQ[0].wr);
          if (wrFlag) begin
            chk(lastDoutEn && lastDout == sbQ[0].d, "R7", "write data on bus", lastDout, sbQ[0].d);
            modelMem[int'(latAddr)] = lastDout;
          end
        end else begin
          chk(1'b0, "R2", "CE cycle without accepted request", latAddr, 0);
        end
      end else if (memCeN) begin
        hiCnt++;
      end
      if (prevDone) chk(!done, "R8", "done wider than one clock", done, 0);
      if (done) begin
        if (sbQ.size() == 0) begin
          chk(1'b0, "R2", "done without accepted request", 1, 0);
        end else begin
          item_t it;
          it = sbQ.pop_front();
          chk(cyc == it.due, "R8", "done cycle", cyc, it.due);
          chk(!busy, "R8", "busy during done", busy, 0);
          if (!it.wr) chk(rdData == it.d, "R6", "read byte", rdData, it.d);
        end
      end
      prevDone = done;
      prevCe   = memCeN;
      prevAddr = memAddr;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(memCeN && memWeN && memOeN, "R1", "strobes in reset", {memCeN, memWeN, memOeN}, 7);
    chk(!busy && !done && !memDoutEn, "R1", "flags in reset", {busy, done, memDoutEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(memCeN && memWeN && memOeN, "R1", "strobes after reset", {memCeN, memWeN, memOeN}, 7);
    chk(!busy && !done, "R1", "flags after reset", {busy, done}, 0);

    doAccess(1'b1, 15'h0010, 8'h5A);          // R7
    doAccess(1'b0, 15'h0010, 8'h00);          // R6, back to back R9
    doAccess(1'b1, 15'h7FFF, 8'hC3);
    doAccess(1'b0, 15'h0000, 8'h00);          // unwritten location
    doAccess(1'b0, 15'h7FFF, 8'h00);
    for (int i = 0; i < 6; i++) begin
      doAccess(1'b1, 15'(16'h0100 + i * 16'h0421), 8'(8'h11 * (i + 1)));
    end
    for (int i = 5; i >= 0; i--) begin
      doAccess(1'b0, 15'(16'h0100 + i * 16'h0421), 8'h00);
    end

    // R2: write presented while busy must leave 0x2222 untouched
    fork
      doAccess(1'b1, 15'h1234, 8'h77);
      pokeWhileBusy(15'h2222, 8'hEE);
    join
    doAccess(1'b0, 15'h2222, 8'h00);
    doAccess(1'b0, 15'h1234, 8'h00);

    // R9 back-to-back was covered above; now a gap in idle
    repeat (7) @(negedge clk);
    doAccess(1'b1, 15'h4000, 8'hA5);
    doAccess(1'b0, 15'h4000, 8'h00);

    @(negedge clk);
    while (busy || sbQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(sbQ.size() == 0, "R8", "outstanding items", sbQ.size(), 0);
    summary();
    $finish;
  end

endmodule